// File: doc/BRIEF.md
# Receive Discard and Early-Receive Monitor

This block runs beside a packet receive path and watches three plain strobes: a packet begins, a byte is written to buffer memory, and a packet ends. It does three jobs with them. It keeps an 8-bit count of packets thrown away because an external discard pin was high at packet end. It lets software abort the packet in flight with a command bit that clears itself. It raises an early-receive flag once the current packet has more bytes in memory than a programmable threshold, where the threshold is counted in 64-byte units.

Every event lands in a sticky interrupt status byte. Software clears a status bit by writing a one to it. A small register port gives access to three registers, chosen by `reg_sel_i`:

| Select | Register | Access |
|---|---|---|
| 0 | drop count | read returns the count and then clears it |
| 1 | status | read has no side effect; writing 1 clears a bit |
| 2 | command | bit 0 requests an abort; a read returns the pending abort |

None of the interfaces carries a data stream, so there is no valid/ready handshake and no back-pressure. The strobes are single-cycle qualifiers that the block samples on every clock. The block never stalls the receive path; it only drives `rx_discard_o` back to it.

Top module: `rx_drop_monitor`

## Requirements
- R1: After reset, `irq_status_o` is 0x00, `rx_discard_o` is 0 and the drop count reads 0x00.
- R2: A packet end that arrives while a packet is open and while `ext_disc_i` is high adds one to the drop count.
- R3: A read with select 0 returns the current drop count on `reg_rdata_o` in that same cycle. The count is 0x00 after that edge.
- R4: If a select-0 read and a drop increment fall in the same cycle, the read returns the old value and the count becomes 0x01 afterwards.
- R5: When an increment takes the drop count to 0xFF, status bit 6 is set. The next increment wraps the count to 0x00.
- R6: Writing 1 to command bit 0 while a packet is open raises `rx_discard_o` and makes the command register read back 0x01. When that packet ends, status bit 4 is set, bit 0 is not set, and the command bit and `rx_discard_o` return to 0.
- R7: An abort command written while no packet is open is ignored. The command register reads 0x00, `rx_discard_o` stays 0, and the next packet completes normally.
- R8: A packet that ends with no abort pending and with `ext_disc_i` low sets status bit 0.
- R9: Status bit 2 is set by the byte that takes the packet's byte count above threshold × 64. A count equal to that product does not set it. A threshold of 0 fires on the first byte.
- R10: The early-receive bit is set at most once per packet; bytes after an acknowledge do not set it again. The byte count restarts at each packet start.
- R11: Status bits stay set until a 1 is written to that bit position with select 1. Writing 0 to a bit leaves it unchanged.
- R12: A packet that ends with `ext_disc_i` high sets neither status bit 0 nor status bit 4 unless an abort was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| pkt_start_i | input | 1 | Pulse: a new packet begins |
| byte_wr_i | input | 1 | Pulse: one byte of the open packet was written |
| pkt_end_i | input | 1 | Pulse: the open packet ends |
| ext_disc_i | input | 1 | External discard pin, sampled at packet end |
| reg_sel_i | input | 2 | Register select: 0 drop count, 1 status, 2 command |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| thr_i | input | 8 | Early-receive threshold in 64-byte units |
| irq_status_o | output | 8 | Sticky status: bit 0 done, bit 2 early, bit 4 aborted, bit 6 drop count full |
| rx_discard_o | output | 1 | Discard request to the receive path for the open packet |

## Verification
The bench targets the edges of the early-receive threshold. It writes exactly threshold × 64 bytes and expects no flag, then writes one more byte and expects the flag. A design that compared with `>=` would flag one byte early. It also checks that the flag does not come back after an acknowledge within the same packet.

The bench drives a count read and a drop in the same cycle. A design that let the clear win would lose that drop and read 0x00 instead of 0x01.

The bench then drives the counter through 0xFF and one step further. A design that failed to wrap would saturate at 0xFF. A design that flagged on the wrong value would set bit 6 too early or not at all.

Finally, the bench sends an abort outside any packet and inside a packet. A design that latched the idle abort would mark the next healthy packet as aborted.

// File: rtl/rxmon_pkg.sv
package rxmon_pkg;
  localparam int STAT_W = 8;

  // status bit positions
  localparam int ST_DONE    = 0;
  localparam int ST_EARLY   = 2;
  localparam int ST_ABORTED = 4;
  localparam int ST_FULL    = 6;

  typedef enum logic [1:0] {
    SEL_DROP = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CMD  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rxmon_drop_counter.sv
module rxmon_drop_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  // a read clears first; a same-cycle increment then lands on the cleared value
  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= inc_i ? ONE : '0;
    else if (inc_i) cnt_q <= cnt_q + ONE;
  end

  assign full_o = inc_i && !clr_i && (cnt_q == ALL_ONES - ONE);
  assign cnt_o  = cnt_q;

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i && !clr_i |=> cnt_q == $past(cnt_q) + ONE) else $error("drop step"); // R2
  AST_READ_KEEPS_INC: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == (($past(inc_i)) ? ONE : '0)) else $error("read clear"); // R4
  AST_FULL_AT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |=> cnt_q == ALL_ONES) else $error("full flag"); // R5
endmodule

// File: rtl/rxmon_abort_ctrl.sv
module rxmon_abort_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_pkt_i,
  input  logic pkt_start_i,
  input  logic end_evt_i,
  input  logic cmd_set_i,
  output logic abort_o
);
  logic abort_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        abort_q <= 1'b0;
    else if (pkt_start_i || end_evt_i) abort_q <= 1'b0;
    else if (cmd_set_i && in_pkt_i)    abort_q <= 1'b1;
  end

  assign abort_o = abort_q;

  AST_ABORT_ONLY_IN_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> in_pkt_i) else $error("abort outside packet"); // R7
  AST_ABORT_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt_i |=> !abort_q) else $error("abort not cleared"); // R6
endmodule

// File: rtl/rxmon_early_detect.sv
module rxmon_early_detect #(
  parameter int THR_W      = 8,
  parameter int UNIT_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_start_i,
  input  logic             in_pkt_i,
  input  logic             byte_wr_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             fire_o
);
  localparam int BC_W = THR_W + UNIT_SHIFT + 1;
  localparam logic [BC_W-1:0] BC_MAX = {BC_W{1'b1}};
  localparam logic [BC_W-1:0] BC_ONE = BC_W'(1);

  logic [BC_W-1:0] bytes_q;
  logic [BC_W-1:0] bytes_nxt;
  logic [BC_W-1:0] limit;
  logic            fired_q;
  logic            counting;

  assign limit     = {1'b0, thr_i, {UNIT_SHIFT{1'b0}}};
  assign counting  = in_pkt_i && byte_wr_i && !pkt_start_i;
  assign bytes_nxt = (bytes_q == BC_MAX) ? BC_MAX : bytes_q + BC_ONE;
  assign fire_o    = counting && !fired_q && (bytes_nxt > limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bytes_q <= '0;
      fired_q <= 1'b0;
    end else if (pkt_start_i) begin
      bytes_q <= '0;
      fired_q <= 1'b0;
    end else begin
      if (counting) bytes_q <= bytes_nxt;
      if (fire_o)   fired_q <= 1'b1;
    end
  end

  AST_EARLY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fired_q && !pkt_start_i |-> !fire_o) else $error("early twice"); // R10
  AST_EARLY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> fired_q) else $error("early not latched"); // R10
endmodule

// File: rtl/rxmon_status.sv
module rxmon_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  for (genvar b = 0; b < W; b++) begin : g_bit
    // a new event in the same cycle as its acknowledge is kept
    always_ff @(posedge clk) begin
      if (!rst_n) stat_q[b] <= 1'b0;
      else        stat_q[b] <= set_i[b] | (stat_q[b] & ~ack_i[b]);
    end

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[b] && !ack_i[b] |=> stat_q[b]) else $error("status dropped"); // R11
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/rx_drop_monitor.sv
module rx_drop_monitor
  import rxmon_pkg::*;
#(
  parameter int THR_W      = 8,
  parameter int UNIT_SHIFT = 6,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_start_i,
  input  logic             byte_wr_i,
  input  logic             pkt_end_i,
  input  logic             ext_disc_i,
  input  logic [1:0]       reg_sel_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic [THR_W-1:0] thr_i,
  output logic [7:0]       irq_status_o,
  output logic             rx_discard_o
);
  logic              in_pkt_q;
  logic              end_evt;
  logic              drop_inc;
  logic              cnt_clr;
  logic              cnt_full;
  logic [CNT_W-1:0]  drop_cnt;
  logic              abort_q;
  logic              early_fire;
  logic              cmd_set;
  logic [STAT_W-1:0] stat_set;
  logic [STAT_W-1:0] stat_ack;
  logic [STAT_W-1:0] stat;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(reg_sel_i);

  // packet framing
  always_ff @(posedge clk) begin
    if (!rst_n)           in_pkt_q <= 1'b0;
    else if (pkt_start_i) in_pkt_q <= 1'b1;
    else if (pkt_end_i)   in_pkt_q <= 1'b0;
  end

  assign end_evt  = in_pkt_q && pkt_end_i && !pkt_start_i;
  assign drop_inc = end_evt && ext_disc_i;
  assign cnt_clr  = reg_rd_i && (sel == SEL_DROP);
  assign cmd_set  = reg_wr_i && (sel == SEL_CMD) && reg_wdata_i[0];

  rxmon_drop_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_i(drop_inc), .clr_i(cnt_clr),
    .cnt_o(drop_cnt), .full_o(cnt_full)
  );

  rxmon_abort_ctrl u_abort (
    .clk(clk), .rst_n(rst_n), .in_pkt_i(in_pkt_q), .pkt_start_i(pkt_start_i),
    .end_evt_i(end_evt), .cmd_set_i(cmd_set), .abort_o(abort_q)
  );

  rxmon_early_detect #(.THR_W(THR_W), .UNIT_SHIFT(UNIT_SHIFT)) u_early (
    .clk(clk), .rst_n(rst_n), .pkt_start_i(pkt_start_i), .in_pkt_i(in_pkt_q),
    .byte_wr_i(byte_wr_i), .thr_i(thr_i), .fire_o(early_fire)
  );

  always_comb begin
    stat_set             = '0;
    stat_set[ST_DONE]    = end_evt && !abort_q && !ext_disc_i;
    stat_set[ST_ABORTED] = end_evt && abort_q;
    stat_set[ST_EARLY]   = early_fire;
    stat_set[ST_FULL]    = cnt_full;
  end

  assign stat_ack = (reg_wr_i && sel == SEL_STAT) ? reg_wdata_i[STAT_W-1:0] : '0;

  rxmon_status #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(stat_set), .ack_i(stat_ack), .stat_o(stat)
  );

  always_comb begin
    case (sel)
      SEL_DROP: reg_rdata_o = 8'(drop_cnt);
      SEL_STAT: reg_rdata_o = stat;
      SEL_CMD:  reg_rdata_o = {7'd0, abort_q};
      default:  reg_rdata_o = 8'd0;
    endcase
  end

  assign irq_status_o = stat;
  assign rx_discard_o = abort_q;

  AST_ABORT_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt && rx_discard_o |=> !irq_status_o[ST_DONE] || $past(irq_status_o[ST_DONE]))
    else $error("aborted packet marked done"); // R6
  AST_EXT_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt && ext_disc_i && !irq_status_o[ST_DONE] |=> !irq_status_o[ST_DONE])
    else $error("pin-dropped packet marked done"); // R12
endmodule

// File: tb/sim_rx_drop_monitor.sv
module sim_rx_drop_monitor;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pkt_start_i = 0, byte_wr_i = 0, pkt_end_i = 0, ext_disc_i = 0;
  logic [1:0] reg_sel_i = 0;
  logic       reg_wr_i = 0, reg_rd_i = 0;
  logic [7:0] reg_wdata_i = 0;
  logic [7:0] reg_rdata_o;
  logic [7:0] thr_i = 8'd1;
  logic [7:0] irq_status_o;
  logic       rx_discard_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_drop_monitor u0 (
    .clk(clk), .rst_n(rst_n), .pkt_start_i(pkt_start_i), .byte_wr_i(byte_wr_i),
    .pkt_end_i(pkt_end_i), .ext_disc_i(ext_disc_i), .reg_sel_i(reg_sel_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .thr_i(thr_i), .irq_status_o(irq_status_o),
    .rx_discard_o(rx_discard_o)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && reg_rd_i) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL scoreboard: unexpected read got %02h expected none", reg_rdata_o);
      end else begin
        check(tag_q.pop_front(), reg_rdata_o, exp_q.pop_front());
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic start_pkt();
    pkt_start_i = 1; tick(); pkt_start_i = 0;
  endtask

  task automatic put_bytes(input int n);
    for (int i = 0; i < n; i++) begin byte_wr_i = 1; tick(); end
    byte_wr_i = 0;
  endtask

  task automatic end_pkt(input logic ext);
    pkt_end_i = 1; ext_disc_i = ext; tick(); pkt_end_i = 0; ext_disc_i = 0;
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [7:0] d);
    reg_sel_i = sel; reg_wdata_i = d; reg_wr_i = 1; tick(); reg_wr_i = 0;
  endtask

  task automatic reg_read(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    reg_sel_i = sel; reg_rd_i = 1; tick(); reg_rd_i = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    check("R1 status", irq_status_o, 8'h00);
    check("R1 discard", {7'd0, rx_discard_o}, 8'h00);
    reg_read(2'd0, 8'h00, "R1 count");

    // R8 normal packet
    start_pkt(); put_bytes(10); end_pkt(0);
    reg_read(2'd1, 8'h01, "R8 done bit");
    // R11 write 0 keeps, write 1 clears
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, 8'h01, "R11 write zero keeps");
    reg_write(2'd1, 8'h01);
    reg_read(2'd1, 8'h00, "R11 write one clears");

    // R9 threshold edge (thr=1 -> 64 bytes)
    start_pkt(); put_bytes(64);
    check("R9 equal no flag", irq_status_o & 8'h04, 8'h00);
    put_bytes(1);
    check("R9 above flags", irq_status_o & 8'h04, 8'h04);
    // R10 once per packet
    reg_write(2'd1, 8'h04);
    put_bytes(5);
    check("R10 no refire", irq_status_o & 8'h04, 8'h00);
    end_pkt(0);
    check("R8 done after early", irq_status_o, 8'h01);
    reg_write(2'd1, 8'hFF);
    // R10 count restarts: 10 bytes on new packet stays quiet
    start_pkt(); put_bytes(10); end_pkt(0);
    check("R10 restart", irq_status_o, 8'h01);
    reg_write(2'd1, 8'hFF);

    // R6 abort inside packet
    start_pkt(); put_bytes(3);
    reg_write(2'd2, 8'h01);
    check("R6 discard high", {7'd0, rx_discard_o}, 8'h01);
    reg_read(2'd2, 8'h01, "R6 cmd readback");
    end_pkt(0);
    check("R6 aborted status", irq_status_o, 8'h10);
    check("R6 discard low", {7'd0, rx_discard_o}, 8'h00);
    reg_read(2'd2, 8'h00, "R6 self clear");
    reg_write(2'd1, 8'hFF);

    // R7 abort while idle
    reg_write(2'd2, 8'h01);
    check("R7 discard stays low", {7'd0, rx_discard_o}, 8'h00);
    reg_read(2'd2, 8'h00, "R7 cmd ignored");
    start_pkt(); put_bytes(2); end_pkt(0);
    check("R7 next packet normal", irq_status_o, 8'h01);
    reg_write(2'd1, 8'hFF);

    // R12 / R2 / R3 external discard
    start_pkt(); end_pkt(1);
    check("R12 no status", irq_status_o, 8'h00);
    reg_read(2'd0, 8'h01, "R2 count one");
    reg_read(2'd0, 8'h00, "R3 read cleared");

    // R4 read and increment in one cycle
    start_pkt(); end_pkt(1);
    start_pkt(); end_pkt(1);
    start_pkt();
    exp_q.push_back(8'h02); tag_q.push_back("R4 old value");
    reg_sel_i = 2'd0; reg_rd_i = 1; pkt_end_i = 1; ext_disc_i = 1;
    tick();
    reg_rd_i = 0; pkt_end_i = 0; ext_disc_i = 0;
    reg_read(2'd0, 8'h01, "R4 increment kept");

    // R5 full flag and wrap
    for (int i = 0; i < 254; i++) begin start_pkt(); end_pkt(1); end
    check("R5 no flag at FE", irq_status_o & 8'h40, 8'h00);
    start_pkt(); end_pkt(1);
    check("R5 flag at FF", irq_status_o & 8'h40, 8'h40);
    start_pkt(); end_pkt(1);
    reg_read(2'd0, 8'h00, "R5 wrap");
    reg_write(2'd1, 8'hFF);

    // R9 threshold zero
    thr_i = 8'd0;
    start_pkt(); put_bytes(1);
    check("R9 zero threshold", irq_status_o & 8'h04, 8'h04);
    end_pkt(0);

    tick();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule